// File: doc/BRIEF.md
# Pointer Load/Store Address Unit

This unit sits in the execute stage of an 8-bit load/store core. Each cycle it may take one decoded data-memory instruction word, along with the following word when the instruction carries a full address. It forms the effective data-space address from one of three pointer pairs held in the register file, or from that following word. It raises a memory strobe that says whether the access reads or writes. For auto-modify modes it also hands back the new pointer value for the register file to write.

Five ways of forming the address are handled: plain pointer, pointer with increment after use, pointer with decrement before use, pointer plus a small unsigned displacement, and a direct 16-bit address. An optional segment byte can extend any of these to 24 bits. Each produced address is also sorted into one of five data-space regions, so that the surrounding core can steer the access to the register file, the I/O blocks or SRAM. Encodings in the load/store group that this unit does not accept are reported as illegal, and no side effect is produced for them.

Top module: `ldst_agu`

## Requirements
- R1: After reset, and until the first accepted instruction, `mem_req`, `mem_we`, `wb_en` and `illegal` are all 0.
- R2: Pointer X is {px_hi,px_lo}, Y is {py_hi,py_lo} and Z is {pz_hi,pz_lo}. Group words `1001 00sd dddd 1100` address through X unchanged and give no write-back.
- R3: In the group `1001 00sd dddd`, low nibble 1101 (X), 1001 (Y) or 0001 (Z) uses the pointer as the address. It then writes back pointer+1 (`wb_sel` 0=X, 1=Y, 2=Z).
- R4: Low nibble 1110 (X), 1010 (Y) or 0010 (Z) uses pointer-1 as the address and also writes back pointer-1.
- R5: A word `10q0 qqsd dddd yqqq` is a displacement access with no write-back. The offset bit 5 is at word bit 13, offset bits 4:3 are at bits 11:10, and offset bits 2:0 are at bits 2:0. y=1 selects Y and y=0 selects Z. The address is pointer+offset, taken modulo 2^16.
- R6: Group low nibble 0000 is a direct access. The address is `ext_word`.
- R7: Bit 9 (s) gives the direction: `mem_we` is 1 for a store and 0 for a load.
- R8: With `ext_en`=1, address bits 23:16 come from the segment of the pointer used (`seg_x`/`seg_y`/`seg_z`), or from `seg_d` for a direct access. With `ext_en`=0 they are 0. Increment, decrement and displacement wrap within 16 bits and never carry into the segment.
- R9: Group low nibbles 1000, 1011, 0011 and any other nibble not listed above raise `illegal`, with `mem_req`=0 and `wb_en`=0.
- R10: `region` is 0 for 0x000000-0x00001F, 1 for 0x000020-0x00003F, 2 for 0x000040-0x00005F, 3 for 0x000060-0x0000FF, and 4 for everything from 0x000100 up.
- R11: Results appear one clock after `valid` is sampled high. When `valid` is 0, or the word is not a data-memory instruction, `mem_req`, `wb_en` and `illegal` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Instruction word present this cycle |
| insn | input | 16 | Load/store instruction word |
| ext_word | input | 16 | Second word carrying a direct address |
| px_lo | input | 8 | X pointer low byte |
| px_hi | input | 8 | X pointer high byte |
| py_lo | input | 8 | Y pointer low byte |
| py_hi | input | 8 | Y pointer high byte |
| pz_lo | input | 8 | Z pointer low byte |
| pz_hi | input | 8 | Z pointer high byte |
| ext_en | input | 1 | Enable 24-bit segmented addressing |
| seg_x | input | 8 | Segment byte for X |
| seg_y | input | 8 | Segment byte for Y |
| seg_z | input | 8 | Segment byte for Z |
| seg_d | input | 8 | Segment byte for direct access |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = store, 0 = load |
| addr | output | 24 | Effective data-space address |
| region | output | 3 | Region class of `addr` |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to update: 0 X, 1 Y, 2 Z |
| wb_val | output | 16 | New pointer value |
| illegal | output | 1 | Reserved encoding seen |

## Verification
Every output is registered once, so the result for a word is due exactly one clock after the edge that samples `valid`. The driver applies one word per cycle at the falling edge and queues exactly one expected record for that cycle, idle cycles included. The monitor samples shortly after each rising edge and pops the record for the word captured at that edge, so each result is matched against the word that produced it. The address, direction and region fields are compared only when a strobe is expected, and the write-back fields only when a write-back is expected.

// File: rtl/ldst_agu.sv
module ldst_agu #(
  parameter int PW = 16,
  parameter int SW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic [15:0]        insn,
  input  logic [PW-1:0]      ext_word,
  input  logic [7:0]         px_lo,
  input  logic [7:0]         px_hi,
  input  logic [7:0]         py_lo,
  input  logic [7:0]         py_hi,
  input  logic [7:0]         pz_lo,
  input  logic [7:0]         pz_hi,
  input  logic               ext_en,
  input  logic [SW-1:0]      seg_x,
  input  logic [SW-1:0]      seg_y,
  input  logic [SW-1:0]      seg_z,
  input  logic [SW-1:0]      seg_d,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PW+SW-1:0]   addr,
  output logic [2:0]         region,
  output logic               wb_en,
  output logic [1:0]         wb_sel,
  output logic [PW-1:0]      wb_val,
  output logic               illegal
);
  localparam int AW = PW + SW;
  localparam logic [1:0] SEL_X = 2'd0, SEL_Y = 2'd1, SEL_Z = 2'd2;

  wire [PW-1:0] ptr_x = PW'({px_hi, px_lo});
  wire [PW-1:0] ptr_y = PW'({py_hi, py_lo});
  wire [PW-1:0] ptr_z = PW'({pz_hi, pz_lo});

  wire       in_grp  = insn[15:10] == 6'b100100;
  wire       in_disp = insn[15:14] == 2'b10 && !insn[12];
  wire [5:0] ofs     = {insn[13], insn[11:10], insn[2:0]};

  logic       hit, bad, inc, dec, dir;
  logic [1:0] sel;

  always_comb begin
    hit = 1'b0; bad = 1'b0; inc = 1'b0; dec = 1'b0; dir = 1'b0;
    sel = SEL_Z;
    if (in_disp) begin
      hit = 1'b1;
      sel = insn[3] ? SEL_Y : SEL_Z;
    end else if (in_grp) begin
      hit = 1'b1;
      case (insn[3:0])
        4'b0000: dir = 1'b1;
        4'b1100: sel = SEL_X;
        4'b1101: begin sel = SEL_X; inc = 1'b1; end
        4'b1110: begin sel = SEL_X; dec = 1'b1; end
        4'b1001: begin sel = SEL_Y; inc = 1'b1; end
        4'b1010: begin sel = SEL_Y; dec = 1'b1; end
        4'b0001: inc = 1'b1;
        4'b0010: dec = 1'b1;
        default: begin hit = 1'b0; bad = 1'b1; end
      endcase
    end
  end

  wire [PW-1:0] ptr = sel == SEL_X ? ptr_x : sel == SEL_Y ? ptr_y : ptr_z;
  wire [SW-1:0] pseg = sel == SEL_X ? seg_x : sel == SEL_Y ? seg_y : seg_z;

  wire [PW-1:0] ea = dir     ? ext_word :
                     dec     ? ptr - PW'(1) :
                     in_disp ? ptr + PW'(ofs) : ptr;
  wire [SW-1:0] seg = !ext_en ? '0 : dir ? seg_d : pseg;
  wire [AW-1:0] full = {seg, ea};

  logic [2:0] rgn;
  always_comb begin
    if (full[AW-1:8] != '0)  rgn = 3'd4;
    else if (full[7:5] == 3'd0) rgn = 3'd0;
    else if (full[7:5] == 3'd1) rgn = 3'd1;
    else if (full[7:5] == 3'd2) rgn = 3'd2;
    else rgn = 3'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req <= 1'b0; mem_we <= 1'b0; addr <= '0; region <= '0;
      wb_en <= 1'b0; wb_sel <= '0; wb_val <= '0; illegal <= 1'b0;
    end else begin
      mem_req <= valid && hit;
      mem_we  <= valid && hit && insn[9];
      illegal <= valid && bad;
      wb_en   <= valid && hit && (inc || dec);
      addr    <= full;
      region  <= rgn;
      wb_sel  <= sel;
      wb_val  <= inc ? ptr + PW'(1) : ptr - PW'(1);
    end
  end

  AST_REQ_ILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && illegal)); // R9
  AST_WB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> mem_req); // R3
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_val == addr[PW-1:0] + PW'(1)) || (wb_val == addr[PW-1:0])); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(valid) |-> !mem_req && !wb_en && !illegal); // R11
  AST_DISP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid && in_disp) |-> mem_req && !wb_en); // R5
  AST_LOW_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && addr[AW-1:5] == '0 |-> region == 3'd0); // R10
endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;
  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, ext_en = 1'b0;
  logic [15:0] insn = '0, ext_word = '0;
  logic [7:0] px_lo = 8'h34, px_hi = 8'h12, py_lo = 8'h50, py_hi = 8'h00, pz_lo = 8'hFF, pz_hi = 8'hFF;
  logic [7:0] seg_x = 8'hA1, seg_y = 8'hB2, seg_z = 8'hC3, seg_d = 8'hD4;
  logic mem_req, mem_we, wb_en, illegal;
  logic [23:0] addr;
  logic [2:0] region;
  logic [1:0] wb_sel;
  logic [15:0] wb_val;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct {
    logic req, we, wb, ill;
    logic [23:0] a;
    logic [2:0] rg;
    logic [1:0] sel;
    logic [15:0] wv;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ldst_agu u0 (.clk(clk), .rst_n(rst_n), .valid(valid), .insn(insn), .ext_word(ext_word),
    .px_lo(px_lo), .px_hi(px_hi), .py_lo(py_lo), .py_hi(py_hi), .pz_lo(pz_lo), .pz_hi(pz_hi),
    .ext_en(ext_en), .seg_x(seg_x), .seg_y(seg_y), .seg_z(seg_z), .seg_d(seg_d),
    .mem_req(mem_req), .mem_we(mem_we), .addr(addr), .region(region), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_val(wb_val), .illegal(illegal));

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [15:0] w, input logic [15:0] xw,
                      input logic req, input logic we, input logic [23:0] a, input logic [2:0] rg,
                      input logic wb, input logic [1:0] sel, input logic [15:0] wv,
                      input logic ill, input string tag);
    exp_t e;
    @(negedge clk);
    valid = v; insn = w; ext_word = xw;
    e.req = req; e.we = we; e.a = a; e.rg = rg; e.wb = wb; e.sel = sel; e.wv = wv; e.ill = ill; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " req"}, 24'(mem_req), 24'(e.req));
      chk({e.tag, " wb"}, 24'(wb_en), 24'(e.wb));
      chk({e.tag, " ill"}, 24'(illegal), 24'(e.ill));
      if (e.req) begin
        chk({e.tag, " addr"}, addr, e.a);
        chk({e.tag, " we"}, 24'(mem_we), 24'(e.we));
        chk({e.tag, " region"}, 24'(region), 24'(e.rg));
      end
      if (e.wb) begin
        chk({e.tag, " sel"}, 24'(wb_sel), 24'(e.sel));
        chk({e.tag, " wbval"}, 24'(wb_val), 24'(e.wv));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", 24'(mem_req), 24'd0);
    chk("R1 we", 24'(mem_we), 24'd0);
    chk("R1 wb", 24'(wb_en), 24'd0);
    chk("R1 ill", 24'(illegal), 24'd0);
    rst_n = 1'b1;
    // R2 plain X load
    send(1, 16'h900C, 0, 1, 0, 24'h001234, 4, 0, 0, 0, 0, "R2 X plain");
    // R3 R7 X post-inc store
    send(1, 16'h920D, 0, 1, 1, 24'h001234, 4, 1, 0, 16'h1235, 0, "R3 R7 X+ store");
    // R4 X pre-dec
    send(1, 16'h900E, 0, 1, 0, 24'h001233, 4, 1, 0, 16'h1233, 0, "R4 -X");
    // R3 R8 Z post-inc wraps
    send(1, 16'h9001, 0, 1, 0, 24'h00FFFF, 4, 1, 2, 16'h0000, 0, "R3 R8 Z+ wrap");
    // R4 R10 Y pre-dec into plain I/O window
    send(1, 16'h900A, 0, 1, 0, 24'h00004F, 2, 1, 1, 16'h004F, 0, "R4 R10 -Y");
    // R5 Y + 63 -> extended I/O
    send(1, 16'hAC0F, 0, 1, 0, 24'h00008F, 3, 0, 0, 0, 0, "R5 Y+63");
    // R5 R10 Z + 32 store wraps into register window
    send(1, 16'hA200, 0, 1, 1, 24'h00001F, 0, 0, 0, 0, 0, "R5 R10 Z+32");
    // R5 Y + 26 checks split fields
    send(1, 16'h8C0A, 0, 1, 0, 24'h00006A, 3, 0, 0, 0, 0, "R5 Y+26");
    // R6 R10 direct load into bit I/O window
    send(1, 16'h9000, 16'h0025, 1, 0, 24'h000025, 1, 0, 0, 0, 0, "R6 R10 direct");
    // R6 R7 direct store to SRAM
    send(1, 16'h9200, 16'h0100, 1, 1, 24'h000100, 4, 0, 0, 0, 0, "R6 R7 direct st");
    // R9 reserved patterns
    send(1, 16'h9008, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 1000");
    send(1, 16'h900B, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 1011");
    send(1, 16'h9203, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 0011");
    // R11 idle and non-memory words
    send(0, 16'h900D, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 valid low");
    send(1, 16'h0C00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 non-mem");
    // R8 segmented addressing
    @(negedge clk); ext_en = 1'b1; valid = 1'b0;
    q.push_back('{req:0, we:0, wb:0, ill:0, a:0, rg:0, sel:0, wv:0, tag:"R11 gap"});
    send(1, 16'h900D, 0, 1, 0, 24'hA11234, 4, 1, 0, 16'h1235, 0, "R8 seg X+");
    send(1, 16'h9001, 0, 1, 0, 24'hC3FFFF, 4, 1, 2, 16'h0000, 0, "R8 seg Z+ no carry");
    send(1, 16'h9000, 16'h0100, 1, 0, 24'hD40100, 4, 0, 0, 0, 0, "R8 seg direct");
    send(1, 16'hAC0F, 0, 1, 0, 24'hB2008F, 4, 0, 0, 0, 0, "R8 R10 seg Y+63");
    send(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule